// File: doc/BRIEF.md
# Two-Stage Cascaded Clock Divider with Coarse Phase Delay

This block divides a source clock through two counting stages in series. Each stage produces an output waveform with a programmable number of high periods and a separately programmable number of low periods. It also has a start level and a coarse start delay, both counted in periods of that stage's own input. The second stage counts one input period for every rising edge of the first stage's output, so its delay and its division multiply onto the first stage's output period.

Everything runs on one fast clock `clk`. One period of the source clock is a cycle in which `src_en` is high. Each stage keeps its output level in a register that can change only on a cycle in which that stage's input period ends. A `sync` pulse captures the configuration fields of both stages into shadow registers and restarts both stages, so the programmed delay is applied again from that point. The configuration inputs may change freely between sync pulses and have no effect until the next one.

For each stage, the 5-bit phase word is 16 × start-high + offset. A phase word of 15 or less delays the first high phase by `offset` input periods. A phase word of 16 or more delays it by `offset + low + 1` input periods.

Top module: `casc_clkdiv`

## Requirements
- R1: In steady state each stage repeats a pattern of `hi + 1` high input periods followed by `lo + 1` low input periods, so one output period lasts `hi + lo + 2` input periods.
- R2: Setting `lo = hi` gives an even ratio with equal high and low time. Setting `lo = hi + 1` gives the odd ratio `2·hi + 3` with `hi + 1` high periods.
- R3: With start-high = 0 and a nonzero offset, the stage output stays low for `offset` input periods after sync, and then the high phase begins.
- R4: With start-high = 1, the output stays high for `offset + lo + 1` input periods after sync and then runs a full high phase of `hi + 1` periods.
- R5: With start-high = 0 and offset = 0, the output is high in the first input period after sync.
- R6: The second stage advances by one input period exactly on each rising edge of the first stage's output. Its delay is therefore counted in first-stage output periods and adds to the first stage's delay.
- R7: The `hi`, `lo`, start-high and offset fields take effect only at a sync pulse. Changing them at any other time leaves both outputs unchanged.
- R8: With a stage's bypass input high, that stage's output and its edge stream equal its input. The first stage's input is `src_en`, and the second stage's input is the first stage's output.
- R9: After reset both outputs are high, and each stage behaves as if synced with all fields zero, giving divide-by-2 starting high.
- R10: A stage's output changes only in a cycle where its input period ends or a sync occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sync | input | 1 | Restart pulse; captures the configuration of both stages |
| src_en | input | 1 | One source-clock input period per high cycle |
| a_hi | input | CW | First stage high count (high periods − 1) |
| a_lo | input | CW | First stage low count (low periods − 1) |
| a_start_hi | input | 1 | First stage start-high bit |
| a_ofs | input | CW | First stage phase offset |
| a_bypass | input | 1 | First stage bypass |
| b_hi | input | CW | Second stage high count |
| b_lo | input | CW | Second stage low count |
| b_start_hi | input | 1 | Second stage start-high bit |
| b_ofs | input | CW | Second stage phase offset |
| b_bypass | input | 1 | Second stage bypass |
| a_out | output | 1 | First stage output level |
| div_out | output | 1 | Second stage (final) output level |
| div_rise | output | 1 | Pulse in the cycle whose clock edge raises the final output |

## Verification
A wrong count or phase register inside a stage shows up at `a_out` within one input period of the fault. The only exception is a fault that lands in a long delay or high phase; that one shows up when the phase should have ended. A fault in the second stage, or a first-stage edge that was lost or doubled, can stay hidden for up to a full second-stage output period, which is many hundreds of clocks. For that reason the bench runs each configuration long enough to cover several final periods. Shadow-register faults appear only when the live fields differ from the captured ones, so the live fields are changed without a sync.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic [1:0] {
    PH_DLY = 2'd0,
    PH_HI  = 2'd1,
    PH_LO  = 2'd2
  } cdiv_phase_e;
endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage
  import cdiv_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  input  logic          tick_in,
  input  logic          lvl_in,
  input  logic          bypass,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  input  logic          start_hi,
  input  logic [CW-1:0] ofs,
  output logic          lvl_out,
  output logic          rise_out
);
  localparam int KW = CW + 1;

  cdiv_phase_e   phase_q, phase_d;
  logic [KW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic [CW-1:0] n_q, n_d;
  logic [CW-1:0] m_q, m_d;
  logic          sh_q, sh_d;

  logic [KW-1:0] ofs_x, lo_x, hi_x, nq_x, mq_x;
  logic [KW-1:0] dly_w;
  logic          rise_core;

  assign ofs_x = {1'b0, ofs};
  assign lo_x  = {1'b0, lo_cnt};
  assign hi_x  = {1'b0, hi_cnt};
  assign nq_x  = {1'b0, n_q};
  assign mq_x  = {1'b0, m_q};

  // phase word >= 16 exactly when start-high is set
  assign dly_w = start_hi ? (ofs_x + lo_x + KW'(1)) : ofs_x;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    lvl_d   = lvl_q;
    n_d     = n_q;
    m_d     = m_q;
    sh_d    = sh_q;
    if (sync) begin
      n_d  = hi_cnt;
      m_d  = lo_cnt;
      sh_d = start_hi;
      if (dly_w == '0) begin
        phase_d = PH_HI;
        cnt_d   = hi_x;
        lvl_d   = 1'b1;
      end else begin
        phase_d = PH_DLY;
        cnt_d   = dly_w - KW'(1);
        lvl_d   = start_hi;
      end
    end else if (tick_in) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - KW'(1);
      end else begin
        unique case (phase_q)
          PH_HI: begin
            phase_d = PH_LO;
            cnt_d   = mq_x;
            lvl_d   = 1'b0;
          end
          default: begin
            phase_d = PH_HI;
            cnt_d   = nq_x;
            lvl_d   = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HI;
      cnt_q   <= '0;
      lvl_q   <= 1'b1;
      n_q     <= '0;
      m_q     <= '0;
      sh_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      lvl_q   <= lvl_d;
      n_q     <= n_d;
      m_q     <= m_d;
      sh_q    <= sh_d;
    end
  end

  assign rise_core = tick_in & ~sync & ~lvl_q & lvl_d;
  assign lvl_out   = bypass ? lvl_in  : lvl_q;
  assign rise_out  = bypass ? tick_in : rise_core;

  // R10: level moves only at an input-period end or a sync
  p_hold_between_ticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_in && !sync) |=> $stable(lvl_q));

  // R7: captured fields move only at sync
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> ($stable(n_q) && $stable(m_q) && $stable(sh_q)));

  // R3 / R4: delay phase holds the captured start level
  p_delay_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DLY) |-> (lvl_q == sh_q));

  // R1: remaining count never exceeds the programmed phase length
  p_hi_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HI) |-> (cnt_q <= nq_x));

  p_lo_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LO) |-> (cnt_q <= mq_x));

  // R1: a fall ends a completed high phase
  p_fall_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lvl_q) && !$past(sync)) |->
      $past(phase_q == PH_HI && cnt_q == '0 && tick_in));
endmodule

// File: rtl/casc_clkdiv.sv
module casc_clkdiv #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  input  logic          src_en,
  input  logic [CW-1:0] a_hi,
  input  logic [CW-1:0] a_lo,
  input  logic          a_start_hi,
  input  logic [CW-1:0] a_ofs,
  input  logic          a_bypass,
  input  logic [CW-1:0] b_hi,
  input  logic [CW-1:0] b_lo,
  input  logic          b_start_hi,
  input  logic [CW-1:0] b_ofs,
  input  logic          b_bypass,
  output logic          a_out,
  output logic          div_out,
  output logic          div_rise
);
  localparam int NST = 2;

  logic          rst_i_n;
  logic [CW-1:0] hi_a  [NST];
  logic [CW-1:0] lo_a  [NST];
  logic [CW-1:0] ofs_a [NST];
  logic [NST-1:0] sh_a;
  logic [NST-1:0] byp_a;
  logic [NST:0]   tick_w;
  logic [NST:0]   lvl_w;

  cdiv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign hi_a[0]  = a_hi;
  assign lo_a[0]  = a_lo;
  assign ofs_a[0] = a_ofs;
  assign hi_a[1]  = b_hi;
  assign lo_a[1]  = b_lo;
  assign ofs_a[1] = b_ofs;
  assign sh_a     = {b_start_hi, a_start_hi};
  assign byp_a    = {b_bypass, a_bypass};

  assign tick_w[0] = src_en;
  assign lvl_w[0]  = src_en;

  for (genvar gi = 0; gi < NST; gi++) begin : g_stage
    cdiv_stage #(.CW(CW)) u_stage (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .sync     (sync),
      .tick_in  (tick_w[gi]),
      .lvl_in   (lvl_w[gi]),
      .bypass   (byp_a[gi]),
      .hi_cnt   (hi_a[gi]),
      .lo_cnt   (lo_a[gi]),
      .start_hi (sh_a[gi]),
      .ofs      (ofs_a[gi]),
      .lvl_out  (lvl_w[gi+1]),
      .rise_out (tick_w[gi+1])
    );
  end

  assign a_out    = lvl_w[1];
  assign div_out  = lvl_w[NST];
  assign div_rise = tick_w[NST];

  // R6: final stage level moves only on a first-stage rise or a sync
  p_cascade_step_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!b_bypass && !tick_w[1] && !sync) |=> $stable(div_out) || $past(b_bypass) != b_bypass);
endmodule

// File: tb/casc_clkdiv_tb.sv
module casc_clkdiv_tb_top;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic src_en = 1'b0;
  logic [CW-1:0] a_hi = '0, a_lo = '0, a_ofs = '0;
  logic [CW-1:0] b_hi = '0, b_lo = '0, b_ofs = '0;
  logic a_start_hi = 1'b0, a_bypass = 1'b0;
  logic b_start_hi = 1'b0, b_bypass = 1'b0;
  logic a_out, div_out, div_rise;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R9";
  bit done = 1'b0;

  always #10 clk = ~clk;

  casc_clkdiv #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync(sync), .src_en(src_en),
    .a_hi(a_hi), .a_lo(a_lo), .a_start_hi(a_start_hi), .a_ofs(a_ofs), .a_bypass(a_bypass),
    .b_hi(b_hi), .b_lo(b_lo), .b_start_hi(b_start_hi), .b_ofs(b_ofs), .b_bypass(b_bypass),
    .a_out(a_out), .div_out(div_out), .div_rise(div_rise)
  );

  // reference model state
  int k1, k2;
  int n1, m1, s1, p1, n2, m2, s2, p2;

  function automatic bit lvl_at(int k, int n, int m, int sh, int po);
    int d;
    d = sh ? (po + m + 1) : po;
    if (k < d) return sh[0];
    return (((k - d) % (n + m + 2)) <= n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k1 = 0; k2 = 0;
      n1 = 0; m1 = 0; s1 = 0; p1 = 0;
      n2 = 0; m2 = 0; s2 = 0; p2 = 0;
    end else if (sync) begin
      k1 = 0; k2 = 0;
      n1 = a_hi; m1 = a_lo; s1 = a_start_hi; p1 = a_ofs;
      n2 = b_hi; m2 = b_lo; s2 = b_start_hi; p2 = b_ofs;
    end else begin
      bit r1;
      r1 = 1'b0;
      if (src_en) begin
        bit o1, w1;
        o1 = lvl_at(k1, n1, m1, s1, p1);
        w1 = lvl_at(k1 + 1, n1, m1, s1, p1);
        k1 = k1 + 1;
        r1 = a_bypass ? 1'b1 : (!o1 && w1);
      end
      if (r1) k2 = k2 + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit e1, e2;
      e1 = a_bypass ? src_en : lvl_at(k1, n1, m1, s1, p1);
      e2 = b_bypass ? e1 : lvl_at(k2, n2, m2, s2, p2);
      n_cmp++;
      if (a_out !== e1) begin
        n_bad++;
        $display("FAIL %s a_out actual=%b expected=%b t=%0t", tag, a_out, e1, $time);
      end
      n_cmp++;
      if (div_out !== e2) begin
        n_bad++;
        $display("FAIL %s div_out actual=%b expected=%b t=%0t", tag, div_out, e2, $time);
      end
    end
  end

  task automatic step(input bit en);
    @(posedge clk);
    #2;
    src_en = en;
  endtask

  task automatic run(input int cyc, input int pat);
    for (int i = 0; i < cyc; i++) step((pat == 0) ? 1'b1 : ((i % 3) != 0));
  endtask

  task automatic do_sync();
    @(posedge clk);
    #2;
    sync = 1'b1;
    @(posedge clk);
    #2;
    sync = 1'b0;
  endtask

  task automatic set_a(input int n, input int m, input int sh, input int po);
    a_hi = CW'(n); a_lo = CW'(m); a_start_hi = sh[0]; a_ofs = CW'(po);
  endtask

  task automatic set_b(input int n, input int m, input int sh, input int po);
    b_hi = CW'(n); b_lo = CW'(m); b_start_hi = sh[0]; b_ofs = CW'(po);
  endtask

  initial begin
    // R9: reset state, then zero configuration divides by 2 starting high
    tag = "R9";
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (5) step(1'b0);
    run(80, 0);

    // R1 R2 R5: even ratio, no delay
    tag = "R2_even";
    set_a(2, 2, 0, 0); set_b(1, 1, 0, 0);
    do_sync(); run(300, 0);

    // R2: odd ratio
    tag = "R2_odd";
    set_a(1, 2, 0, 0); set_b(0, 1, 0, 0);
    do_sync(); run(300, 0);

    // R3: low start with offset, gapped source
    tag = "R3";
    set_a(3, 1, 0, 5); set_b(2, 0, 0, 3);
    do_sync(); run(500, 1);

    // R4: start high, phase word >= 16
    tag = "R4";
    set_a(2, 4, 1, 3); set_b(1, 2, 1, 1);
    do_sync(); run(700, 0);

    // R6: long cascade with both delays, gapped source
    tag = "R6";
    set_a(0, 1, 0, 7); set_b(3, 4, 1, 15);
    do_sync(); run(1500, 1);

    // R7: live fields changed without sync have no effect
    tag = "R7";
    set_a(1, 1, 0, 2); set_b(2, 2, 0, 1);
    do_sync(); run(60, 0);
    set_a(15, 0, 1, 9); set_b(0, 15, 1, 4);
    run(400, 0);
    do_sync(); run(400, 0);

    // R8: bypass of each stage
    tag = "R8";
    set_a(1, 2, 0, 0); set_b(1, 1, 0, 2);
    a_bypass = 1'b1;
    do_sync(); run(200, 1);
    a_bypass = 1'b0; b_bypass = 1'b1;
    do_sync(); run(200, 1);
    b_bypass = 1'b0;

    // R10: sparse source keeps outputs still between periods
    tag = "R10";
    set_a(2, 3, 0, 1); set_b(0, 0, 0, 0);
    do_sync(); run(600, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule